// File: doc/BRIEF.md
# Teletype Output Transfer Controller

This block carries out the I/O-transfer instructions of a 12-bit minicomputer that are aimed at the teletype output device. When an instruction arrives with opcode 6, the block decodes its device field and its function field. It then updates a 12-bit control word, which holds a pending output character, a character-valid bit, a done flag and one extra status bit. The block also tells the sequencer whether to skip the next instruction. If it does, the block supplies the advanced program counter, and the field bits above bit 11 are left untouched.

A downstream serial transmitter reads the pending character through a valid/done handshake. While bit 8 of the control word is set, the character is offered. A one-cycle `tx_done` pulse consumes the character and raises the done flag. Any opcode-6 instruction that is addressed to this device but uses a function the block does not implement raises `illegal` instead.

The character state is held in a two-state machine. `ST_IDLE` means no character is pending, and `ST_BUSY` means a character is waiting for the transmitter. The transitions are as follows:
- A load (function 4 or 6) moves the machine from either state to `ST_BUSY`.
- A flag-set (function 0) or a clear (function 2) moves it from either state to `ST_IDLE`.
- An accepted `tx_done` moves it from `ST_BUSY` to `ST_IDLE`.

Top module: `tto_ctrl`

## Requirements
- R1: While `rst` is high, and after it has been released with no instruction applied, `ctl_word` is 0 and `skip`, `illegal` and `tx_valid` are low.
- R2: Instruction octal 6040 (opcode 6, device 04, function 0) sets `ctl_word` to 0x600 on the next cycle. This sets done flag bit 9 and bit 10 and clears every other bit.
- R3: Instruction 6041 drives `skip` high in the same cycle exactly when bit 9 of `ctl_word` is set, and it leaves `ctl_word` unchanged apart from any R10 handshake.
- R4: Instruction 6042 clears all 12 bits of `ctl_word` on the next cycle.
- R5: Instruction 6044 loads `acc[7:0] XOR 0x80` into bits 7:0 and sets bit 8. Bits 11:9 are kept.
- R6: Instruction 6046 loads `acc[7:0] XOR 0x80` into bits 7:0, sets bit 8 and clears bits 10 and 9. Bit 11 is kept.
- R7: When `skip` is high, `next_pc_out[11:0]` equals `next_pc_in[11:0] + 1` modulo 4096, and the bits above bit 11 are copied unchanged. When `skip` is low, `next_pc_out` equals `next_pc_in`.
- R8: An opcode-6 instruction whose device field (bits 8:3) is not 04, or whose function is 3, 5 or 7, drives `illegal` high in the same cycle. It does not skip and it does not change `ctl_word`.
- R9: Instructions with an opcode other than 6, and any cycle with `instr_valid` low, raise neither `skip` nor `illegal` and do not change `ctl_word`.
- R10: `tx_valid` equals bit 8 and `tx_char` equals bits 7:0 of `ctl_word`. A `tx_done` pulse while `tx_valid` is high clears bit 8 and sets bit 9 on the next cycle, unless a function 0, 2, 4 or 6 instruction arrives in the same cycle. In that case the instruction wins. `tx_done` has no effect while `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 12 | Instruction word |
| acc | input | 12 | Accumulator value |
| next_pc_in | input | PC_W | Next program counter from the sequencer |
| next_pc_out | output | PC_W | Next program counter after any skip |
| skip | output | 1 | Skip decision for this instruction |
| illegal | output | 1 | Unsupported function or device |
| ctl_word | output | 12 | Current control word |
| tx_valid | output | 1 | A character is pending for the transmitter |
| tx_char | output | 8 | Pending character |
| tx_done | input | 1 | Transmitter has taken the character |

## Verification
The bench builds the block with its default values: a 15-bit program counter (PC_W = 15) and device code 04. With three field bits above the 12-bit page, every skip can show both the wrap from 07777 to 0 and the preservation of the field. Random stimulus is biased towards device 04, so all eight function codes appear many times. Many of these land on a pending character together with a `tx_done` pulse, which exercises the instruction-over-handshake priority. The bench also sends foreign device codes and foreign opcodes.

// File: rtl/tto_pkg.sv
package tto_pkg;
    localparam int WORD_W = 12;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SETFLAGS,
        OP_SKIPQ,
        OP_CLEAR,
        OP_LOAD,
        OP_LOADCLR,
        OP_BAD
    } tto_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } tto_state_e;
endpackage

// File: rtl/tto_decode.sv
module tto_decode
    import tto_pkg::*;
#(
    parameter logic [5:0] DEV_CODE = 6'o04
) (
    input  logic              valid,
    input  logic [WORD_W-1:0] instr,
    output tto_op_e           op
);
    localparam logic [2:0] IOT_OPC = 3'o6;

    logic is_iot;
    logic is_dev;

    assign is_iot = valid && (instr[11:9] == IOT_OPC);
    assign is_dev = (instr[8:3] == DEV_CODE);

    always_comb begin
        op = OP_NONE;
        if (is_iot) begin
            if (!is_dev) begin
                op = OP_BAD;
            end else begin
                unique case (instr[2:0])
                    3'd0:    op = OP_SETFLAGS;
                    3'd1:    op = OP_SKIPQ;
                    3'd2:    op = OP_CLEAR;
                    3'd4:    op = OP_LOAD;
                    3'd6:    op = OP_LOADCLR;
                    default: op = OP_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/tto_ctl_fsm.sv
module tto_ctl_fsm
    import tto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tto_op_e           op,
    input  logic [WORD_W-1:0] acc,
    input  logic              tx_done,
    output logic [WORD_W-1:0] ctl
);
    localparam logic [CHAR_W-1:0] CHAR_FLIP = 8'h80;

    tto_state_e        state_q, state_d;
    logic [CHAR_W-1:0] char_q,  char_d;
    logic [2:0]        hi_q,    hi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            char_q  <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            char_q  <= char_d;
            hi_q    <= hi_d;
        end
    end

    always_comb begin
        state_d = state_q;
        char_d  = char_q;
        hi_d    = hi_q;
        unique case (op)
            OP_SETFLAGS: begin
                state_d = ST_IDLE;
                char_d  = '0;
                hi_d    = 3'b011;
            end
            OP_CLEAR: begin
                state_d = ST_IDLE;
                char_d  = '0;
                hi_d    = 3'b000;
            end
            OP_LOAD: begin
                state_d = ST_BUSY;
                char_d  = acc[CHAR_W-1:0] ^ CHAR_FLIP;
            end
            OP_LOADCLR: begin
                state_d = ST_BUSY;
                char_d  = acc[CHAR_W-1:0] ^ CHAR_FLIP;
                hi_d    = {hi_q[2], 2'b00};
            end
            default: begin
                if (tx_done && state_q == ST_BUSY) begin
                    state_d = ST_IDLE;
                    hi_d[0] = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        ctl = {hi_q, (state_q == ST_BUSY), char_q};
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_CLEAR |=> ctl == '0);

    // R2
    setflags_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_SETFLAGS |=> ctl == 12'h600);

    // R5
    load_char_chk: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> (ctl[8] && ctl[7:0] == ($past(acc[7:0]) ^ 8'h80)
                           && ctl[11:9] == $past(ctl[11:9])));

    // R10
    handshake_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && ctl[8] && (op == OP_NONE || op == OP_SKIPQ || op == OP_BAD))
        |=> (!ctl[8] && ctl[9]));
endmodule

// File: rtl/tto_pc_adv.sv
module tto_pc_adv
    import tto_pkg::*;
#(
    parameter int PC_W = 15
) (
    input  logic            skip,
    input  logic [PC_W-1:0] pc_in,
    output logic [PC_W-1:0] pc_out
);
    logic [WORD_W-1:0] page_next;
    assign page_next = pc_in[WORD_W-1:0] + 1'b1;

    generate
        if (PC_W > WORD_W) begin : g_field
            assign pc_out = skip ? {pc_in[PC_W-1:WORD_W], page_next} : pc_in;
        end else begin : g_flat
            assign pc_out = skip ? page_next : pc_in;
        end
    endgenerate
endmodule

// File: rtl/tto_ctrl.sv
module tto_ctrl
    import tto_pkg::*;
#(
    parameter int         PC_W     = 15,
    parameter logic [5:0] DEV_CODE = 6'o04
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [11:0]         instr,
    input  logic [11:0]         acc,
    input  logic [PC_W-1:0]     next_pc_in,
    output logic [PC_W-1:0]     next_pc_out,
    output logic                skip,
    output logic                illegal,
    output logic [11:0]         ctl_word,
    output logic                tx_valid,
    output logic [7:0]          tx_char,
    input  logic                tx_done
);
    tto_op_e op;
    logic    dec_valid;

    assign dec_valid = instr_valid && !rst;

    tto_decode #(.DEV_CODE(DEV_CODE)) u_dec (
        .valid (dec_valid),
        .instr (instr),
        .op    (op)
    );

    tto_ctl_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .acc     (acc),
        .tx_done (tx_done),
        .ctl     (ctl_word)
    );

    assign skip     = (op == OP_SKIPQ) && ctl_word[9];
    assign illegal  = (op == OP_BAD);
    assign tx_valid = ctl_word[8];
    assign tx_char  = ctl_word[7:0];

    tto_pc_adv #(.PC_W(PC_W)) u_pc (
        .skip   (skip),
        .pc_in  (next_pc_in),
        .pc_out (next_pc_out)
    );

    // R8
    skip_vs_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        !(skip && illegal));

    // R8
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal && !tx_done) |=> $stable(ctl_word));

    // R7
    pc_field_chk: assert property (@(posedge clk) disable iff (rst)
        skip |-> (next_pc_out[PC_W-1:12] == next_pc_in[PC_W-1:12]
                  && next_pc_out[11:0] == next_pc_in[11:0] + 12'd1));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (!skip && !illegal));
endmodule

// File: tb/tto_ctrl_tb_top.sv
module tto_ctrl_tb_top;
    localparam int PC_W = 15;

    logic              clk = 1'b0;
    logic              rst;
    logic              instr_valid;
    logic [11:0]       instr;
    logic [11:0]       acc;
    logic [PC_W-1:0]   next_pc_in;
    logic [PC_W-1:0]   next_pc_out;
    logic              skip;
    logic              illegal;
    logic [11:0]       ctl_word;
    logic              tx_valid;
    logic [7:0]        tx_char;
    logic              tx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [11:0] ctl_m;

    always #2.5 clk = ~clk;

    tto_ctrl #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .acc(acc), .next_pc_in(next_pc_in), .next_pc_out(next_pc_out),
        .skip(skip), .illegal(illegal), .ctl_word(ctl_word),
        .tx_valid(tx_valid), .tx_char(tx_char), .tx_done(tx_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_ours(logic iv, logic [11:0] ins);
        return iv && ins[11:9] == 3'o6 && ins[8:3] == 6'o04;
    endfunction

    function automatic bit exp_illegal(logic iv, logic [11:0] ins);
        if (!(iv && ins[11:9] == 3'o6)) return 1'b0;
        if (ins[8:3] != 6'o04) return 1'b1;
        return ins[2:0] == 3'd3 || ins[2:0] == 3'd5 || ins[2:0] == 3'd7;
    endfunction

    function automatic logic [11:0] m_next(logic [11:0] c, logic iv, logic [11:0] ins,
                                           logic [11:0] a, logic d);
        if (is_ours(iv, ins)) begin
            case (ins[2:0])
                3'd0: return 12'h600;
                3'd2: return 12'h000;
                3'd4: return {c[11:9], 1'b1, a[7:0] ^ 8'h80};
                3'd6: return {c[11], 2'b00, 1'b1, a[7:0] ^ 8'h80};
                default: ;
            endcase
        end
        if (d && c[8]) return {c[11:10], 1'b1, 1'b0, c[7:0]};
        return c;
    endfunction

    function automatic string tag_of(logic iv, logic [11:0] ins, logic d, logic [11:0] c);
        if (exp_illegal(iv, ins)) return "R8";
        if (!is_ours(iv, ins)) return (d && c[8]) ? "R10" : "R9";
        case (ins[2:0])
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // drive at negedge, check combinational outputs, then advance the model
    task automatic step(input logic iv, input logic [11:0] ins, input logic [11:0] a,
                        input logic [PC_W-1:0] pc, input logic d);
        logic sk;
        logic [PC_W-1:0] pc_exp;
        string t;
        @(negedge clk);
        instr_valid = iv; instr = ins; acc = a; next_pc_in = pc; tx_done = d;
        #1;
        sk = is_ours(iv, ins) && ins[2:0] == 3'd1 && ctl_m[9];
        pc_exp = sk ? {pc[PC_W-1:12], pc[11:0] + 12'd1} : pc;
        t = tag_of(iv, ins, d, ctl_m);
        check(sk ? "R3 skip" : "R9 skip", {31'd0, skip}, {31'd0, sk});
        check("R8 illegal", {31'd0, illegal}, {31'd0, exp_illegal(iv, ins)});
        check("R7 next_pc", {17'd0, next_pc_out}, {17'd0, pc_exp});
        check("R10 tx_valid", {31'd0, tx_valid}, {31'd0, ctl_m[8]});
        check("R10 tx_char", {24'd0, tx_char}, {24'd0, ctl_m[7:0]});
        @(posedge clk);
        ctl_m = m_next(ctl_m, iv, ins, a, d);
        #1;
        check({t, " ctl_word"}, {20'd0, ctl_word}, {20'd0, ctl_m});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; instr_valid = 1'b0; instr = '0; acc = '0;
        next_pc_in = '0; tx_done = 1'b0; ctl_m = '0;
        // R1: hold reset with a live-looking instruction; outputs stay quiet
        repeat (3) @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b1; instr = 12'o6041; tx_done = 1'b1;
        #1;
        check("R1 skip in reset", {31'd0, skip}, 32'd0);
        check("R1 illegal in reset", {31'd0, illegal}, 32'd0);
        @(negedge clk);
        instr_valid = 1'b0; tx_done = 1'b0; rst = 1'b0;
        #1;
        check("R1 ctl_word", {20'd0, ctl_word}, 32'd0);
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

        // directed corner cases
        step(1, 12'o6041, 12'h000, 15'o00100, 0);   // R3 no skip, flag clear
        step(1, 12'o6040, 12'h000, 15'o00100, 0);   // R2 -> 0x600
        check("R2 value", {20'd0, ctl_word}, 32'h600);
        step(1, 12'o6041, 12'h000, 15'o17777, 0);   // R7 wrap with field kept
        step(1, 12'o6044, 12'h041, 15'o00000, 0);   // R5 -> 0x7C1
        check("R5 value", {20'd0, ctl_word}, 32'h7C1);
        step(1, 12'o6046, 12'h0F3, 15'o00000, 0);   // R6 -> 0x173
        check("R6 value", {20'd0, ctl_word}, 32'h173);
        step(1, 12'o6045, 12'h000, 15'o00000, 1);   // R8 function 5, handshake still taken
        check("R10 done value", {20'd0, ctl_word}, 32'h273);
        step(1, 12'o6044, 12'h000, 15'o00000, 0);   // R5 keeps bit 9 -> 0x380
        step(1, 12'o6042, 12'h000, 15'o00000, 1);   // R4 beats tx_done
        check("R4 value", {20'd0, ctl_word}, 32'h000);
        step(0, 12'o6040, 12'h000, 15'o00000, 1);   // R9 invalid cycle ignored
        step(1, 12'o1040, 12'h000, 15'o00000, 1);   // R9 other opcode, R10 done ignored when idle
        step(1, 12'o6031, 12'h000, 15'o00000, 0);   // R8 other device

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] ins;
            logic [PC_W-1:0] pc;
            int sel;
            sel = $urandom % 8;
            if (sel < 6)      ins = {3'o6, 6'o04, 3'($urandom)};
            else if (sel == 6) ins = {3'o6, 6'($urandom), 3'($urandom)};
            else               ins = 12'($urandom);
            pc = PC_W'($urandom);
            if ($urandom % 4 == 0) pc[11:0] = 12'o7777;
            step(($urandom % 10) != 0, ins, 12'($urandom), pc, ($urandom % 4) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule